// File: doc/BRIEF.md
# Watchdog Reset Generator

This block watches for a periodic keep-alive from firmware and produces a long, fixed-length reset pulse when that keep-alive stops. A free-running prescaler divides the system clock into ticks, and a small tick counter measures the time since the last keep-alive. Firmware keeps the system alive by performing an I/O write of any value to a dedicated write-only address, which clears the tick counter. If the counter reaches its terminal count, the block raises its reset output for a fixed number of cycles. During the pulse the prescaler and tick counter are held at zero, so a fresh timeout starts from a known phase when the pulse releases.

When the pulse releases, the block asserts a one-cycle load strobe together with the restart address (zero), so the processor begins fetching from there. A sticky flag records that a watchdog reset happened. This lets firmware tell it apart from a power-on reset. The flag stays set through the pulse it caused. Firmware clears it by writing zero into its bit of the status register. While the suspend input is high the clock domain is considered stopped: the prescaler and counter freeze, and keep-alive writes are not accepted.

Top module: `wdt_reset_gen`

## Requirements
- R1: An I/O write to address 0x26 restarts the timeout measurement whatever the data value is, as long as suspend is low and no reset pulse is running.
- R2: I/O writes to any other address do not restart the timeout measurement.
- R3: After an accepted keep-alive write, with no further keep-alive and suspend low, `wdr_o` rises after at least (TICKS-1)*PRESCALE+1 and at most TICKS*PRESCALE clock edges. Edges are counted from the edge that captures the write, and the window is due to prescaler phase.
- R4: Starting from the edge where power-on reset is first sampled low, or from the edge where `wdr_o` falls, `wdr_o` rises after exactly TICKS*PRESCALE edges if there is no keep-alive and no suspend.
- R5: Once raised, `wdr_o` stays high for exactly PULSE_LEN clock cycles.
- R6: `vec_load_o` is high for exactly one cycle: the first cycle after `wdr_o` falls. `vec_addr_o` reads 0 at that time.
- R7: `wd_flag_o` becomes 1 in the same cycle `wdr_o` rises and stays 1 through the pulse and afterwards.
- R8: An I/O write to address 0xFF with data bit 6 equal to 0 clears `wd_flag_o`. The same write with bit 6 equal to 1 leaves the flag unchanged.
- R9: While `suspend_i` is high, the prescaler and timeout counter hold their values and keep-alive writes are ignored. The time to `wdr_o` therefore grows by exactly the number of suspended cycles.
- R10: Keep-alive writes made while `wdr_o` is high have no effect. The pulse length and the following timeout of R4 are unchanged.
- R11: While power-on reset is high, `wdr_o`, `wd_flag_o` and `vec_load_o` are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| io_wr | input | 1 | I/O write strobe, one write per cycle it is high |
| io_addr | input | ADDR_W | I/O write address |
| io_wdata | input | DATA_W | I/O write data |
| suspend_i | input | 1 | High while the clock domain is stopped |
| wdr_o | output | 1 | Watchdog reset pulse, active high |
| wd_flag_o | output | 1 | Sticky watchdog-reset status bit |
| vec_load_o | output | 1 | One-cycle strobe to load the restart address |
| vec_addr_o | output | VEC_W | Restart fetch address |

## Verification
The hardest case to reach from the ports is the exact timeout window, because it depends on the hidden prescaler phase at the time of each keep-alive. The stimulus places keep-alive writes after random delays and with random data. It checks that every measured timeout falls in the window and that runs of keep-alives with random gaps never let the reset fire. To pin down the exact counts, it starts from phase-known points: reset release and pulse release. From those points it inserts suspend stretches of random position and length, and it issues keep-alives during a pulse. The expected delay is then known to the cycle.

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int KICK_ADDR = 'h26,
  parameter int STAT_ADDR = 'hFF,
  parameter int FLAG_BIT  = 6,
  parameter int PRESCALE  = 16384,
  parameter int TICKS     = 5,
  parameter int PULSE_LEN = 18000,
  parameter int VEC_W     = 13,
  parameter int RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              por,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              suspend_i,
  output logic              wdr_o,
  output logic              wd_flag_o,
  output logic              vec_load_o,
  output logic [VEC_W-1:0]  vec_addr_o
);

  localparam int PRE_W = (PRESCALE  > 1) ? $clog2(PRESCALE)  : 1;
  localparam int WD_W  = (TICKS     > 1) ? $clog2(TICKS)     : 1;
  localparam int PL_W  = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [WD_W-1:0]   WD_LAST  = WD_W'(TICKS - 1);
  localparam logic [PL_W-1:0]   PL_LAST  = PL_W'(PULSE_LEN - 1);
  localparam logic [ADDR_W-1:0] KICK_A   = ADDR_W'(KICK_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(STAT_ADDR);

  logic [PRE_W-1:0] pre_q;
  logic [WD_W-1:0]  wd_q;
  logic [PL_W-1:0]  pl_q;
  logic             wdr_q, flag_q, vec_q;

  logic run, tick, kick, fire, flag_clr, pulse_end;
  logic unused_data;

  assign run       = !suspend_i && !wdr_q;
  assign tick      = run && (pre_q == PRE_LAST);
  assign kick      = run && io_wr && (io_addr == KICK_A);
  assign fire      = tick && !kick && (wd_q == WD_LAST);
  assign pulse_end = wdr_q && (pl_q == PL_LAST);
  assign flag_clr  = io_wr && (io_addr == STAT_A) && !io_wdata[FLAG_BIT];
  assign unused_data = ^io_wdata;

  always_ff @(posedge clk) begin
    if (por || wdr_q || fire)
      pre_q <= '0;
    else if (!suspend_i)
      pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por || wdr_q || fire || kick)
      wd_q <= '0;
    else if (tick)
      wd_q <= wd_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por)            wdr_q <= 1'b0;
    else if (fire)      wdr_q <= 1'b1;
    else if (pulse_end) wdr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (por || !wdr_q) pl_q <= '0;
    else               pl_q <= pl_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    vec_q <= !por && pulse_end;
  end

  always_ff @(posedge clk) begin
    if (por)           flag_q <= 1'b0;
    else if (fire)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign wdr_o      = wdr_q;
  assign wd_flag_o  = flag_q;
  assign vec_load_o = vec_q;
  assign vec_addr_o = VEC_W'(RESET_VEC);

  // R1
  kick_clear_chk: assert property (@(posedge clk) disable iff (por)
    kick |=> (wd_q == '0));

  // R3
  fire_at_terminal_chk: assert property (@(posedge clk) disable iff (por)
    $rose(wdr_q) |-> ($past(wd_q) == WD_LAST && $past(pre_q) == PRE_LAST));

  // R9
  suspend_freeze_chk: assert property (@(posedge clk) disable iff (por)
    (suspend_i && !wdr_q) |=> (pre_q == $past(pre_q) && wd_q == $past(wd_q)));

  // R10
  pulse_hold_chk: assert property (@(posedge clk) disable iff (por)
    wdr_q |-> (pre_q == '0 && wd_q == '0));

  // R7
  flag_on_fire_chk: assert property (@(posedge clk) disable iff (por)
    $rose(wdr_q) |-> flag_q);

  // R6
  vec_after_pulse_chk: assert property (@(posedge clk) disable iff (por)
    vec_q |-> (!wdr_q && $past(wdr_q)));

endmodule

// File: tb/wdt_reset_gen_tb_top.sv
`timescale 1ns/1ps
module wdt_reset_gen_tb_top;
  localparam int P   = 8;
  localparam int T   = 4;
  localparam int L   = 6;
  localparam int TP  = T * P;
  localparam int WLO = (T - 1) * P + 1;
  localparam logic [7:0] KICK = 8'h26;
  localparam logic [7:0] STAT = 8'hFF;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic suspend_i = 1'b0;
  logic wdr_o, wd_flag_o, vec_load_o;
  logic [12:0] vec_addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_reset_gen #(.PRESCALE(P), .TICKS(T), .PULSE_LEN(L)) dut_i (
    .clk(clk), .por(por), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .suspend_i(suspend_i), .wdr_o(wdr_o), .wd_flag_o(wd_flag_o),
    .vec_load_o(vec_load_o), .vec_addr_o(vec_addr_o));

  function automatic logic [7:0] foreign_addr();
    logic [7:0] a;
    a = 8'($urandom);
    while (a == KICK || a == STAT) a = 8'($urandom);
    return a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_to_rise(output int n);
    n = 0;
    while (!wdr_o && n < 1000) begin step(); n++; end
  endtask

  task automatic measure_pulse(output int len);
    len = 0;
    while (wdr_o && len < 1000) begin step(); len++; end
  endtask

  task automatic kick_write();
    io_wr = 1'b1; io_addr = KICK; io_wdata = 8'($urandom);
    step();
    io_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, len, k, s, pre, hits;
    void'($urandom(32'd2024));
    @(negedge clk);
    repeat (4) step();
    // R11
    check("R11 wdr", int'(wdr_o), 0);
    check("R11 flag", int'(wd_flag_o), 0);
    check("R11 vec_load", int'(vec_load_o), 0);
    por = 1'b0;

    // R4 from power-on
    count_to_rise(n);
    check("R4 por to wdr", n, TP);
    check("R7 flag on fire", int'(wd_flag_o), 1);
    measure_pulse(len);
    check("R5 pulse length", len, L);
    check("R6 vec_load", int'(vec_load_o), 1);
    check("R6 vec_addr", int'(vec_addr_o), 0);
    check("R7 flag sticky", int'(wd_flag_o), 1);
    step();
    check("R6 vec_load single", int'(vec_load_o), 0);
    count_to_rise(n);
    check("R4 release to wdr", n + 1, TP);

    // R10 kicks during the pulse
    len = 0;
    while (wdr_o && len < 1000) begin
      io_wr = 1'b1; io_addr = KICK; io_wdata = 8'($urandom);
      step(); len++;
    end
    io_wr = 1'b0;
    check("R10 pulse length", len, L);
    count_to_rise(n);
    check("R10 release to wdr", n, TP);
    measure_pulse(len);

    // R8 status clear path
    io_wr = 1'b1; io_addr = STAT; io_wdata = 8'($urandom) | 8'h40;
    step();
    check("R8 bit6=1 keeps flag", int'(wd_flag_o), 1);
    io_wdata = 8'($urandom) & 8'hBF;
    step();
    io_wr = 1'b0;
    check("R8 bit6=0 clears flag", int'(wd_flag_o), 0);
    count_to_rise(n);
    check("R7 flag set again", int'(wd_flag_o), 1);
    check("R4 with status writes", n + 2, TP);
    measure_pulse(len);

    // R3 and R1: random phase kicks with random data
    for (int i = 0; i < 12; i++) begin
      k = $urandom_range(0, 2 * P);
      repeat (k) step();
      kick_write();
      count_to_rise(n);
      check_rng("R3 window", n, WLO, TP);
      measure_pulse(len);
      check("R5 pulse length", len, L);
    end

    // R1 and R2: keep-alive runs with foreign writes in the gaps
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      kick_write();
      k = $urandom_range(1, WLO - 2);
      for (int j = 0; j < k; j++) begin
        io_wr = 1'($urandom); io_addr = foreign_addr(); io_wdata = 8'($urandom);
        step();
        if (wdr_o) hits++;
      end
      io_wr = 1'b0;
    end
    check("R1 keep-alive holds off reset", hits, 0);
    kick_write();
    k = $urandom_range(3, 12);
    for (int j = 0; j < k; j++) begin
      io_wr = 1'b1; io_addr = foreign_addr(); io_wdata = 8'($urandom);
      step();
    end
    io_wr = 1'b0;
    count_to_rise(n);
    check_rng("R2 foreign writes ignored", n + k, WLO, TP);
    measure_pulse(len);

    // R9 suspend stretches the timeout exactly
    for (int i = 0; i < 3; i++) begin
      pre = $urandom_range(0, TP - 2);
      s = $urandom_range(1, 20);
      repeat (pre) step();
      suspend_i = 1'b1;
      for (int j = 0; j < s; j++) begin
        io_wr = 1'b1; io_addr = KICK; io_wdata = 8'($urandom);
        step();
      end
      io_wr = 1'b0;
      suspend_i = 1'b0;
      count_to_rise(n);
      check("R9 suspend extends timeout", pre + s + n, TP + s);
      measure_pulse(len);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule